// File: doc/BRIEF.md
# System-to-Card Descriptor Stream Emitter

This block turns a queue of host-to-card transfer descriptors into a framed data stream for user logic. Each descriptor carries an 8-bit control byte, a 20-bit byte count, a 64-bit user control word and a card start address. While a descriptor is active, the data returned by the host reads passes beat by beat to the stream output. Each beat carries a per-beat error indication. The block marks packet start and end from the control byte and presents the user word with the start beat. It produces a burst address for every beat and, on the packet's final beat, a byte-enable mask.

When a descriptor finishes, the block emits a one-cycle status record. The record holds the bytes actually delivered, completion, short and error flags, a 4-bit error-source field that ORs the errors of every beat together, and an interrupt request chosen by the control byte. The read data source may end a descriptor early. The record then reports the truncated byte count.

Top module: `s2c_desc_emitter`

## Requirements
- R1: After reset, desc_ready is 1, st_valid is 0 and wb_valid is 0; a descriptor is taken when desc_valid and desc_ready are both 1.
- R2: While a descriptor is active, st_valid follows rd_valid, rd_ready follows st_ready, st_data equals rd_data, and the descriptor takes ceil(byte_count/16) beats unless it is ended early.
- R3: st_sop is 1 on the first beat exactly when control bit 7 is set; st_user shows the user word in that cycle and is zero in every other cycle.
- R4: st_eop is 1 on the final beat exactly when control bit 6 is set; on that beat st_keep has its low N bits set, N being the remaining bytes capped at 16; every other beat has all 16 keep bits set.
- R5: With control bit 2 clear, st_addr starts at the card address and grows by 16 bytes per beat of each finished burst; bursts are at most 16 beats, and st_burst_first marks the first beat of each.
- R6: With control bit 2 set (addressable FIFO), every beat of the descriptor carries the card address with its low 8 bits forced to zero.
- R7: rd_err bit 2 flags an ECRC error, bit 1 a poisoned completion and bit 0 an unsuccessful completion; these are ORed over all beats of a descriptor into wb_errsrc[2:0], wb_errsrc[3] is 0, and the field restarts at zero for the next descriptor.
- R8: wb_flags has bit 4 (error) set when any error source is set, bit 0 (complete) set when none is, and bit 1 (short) set when the delivered bytes are fewer than programmed; bits 7:5 and 3:2 are zero.
- R9: A beat with rd_stop set is the descriptor's final beat; wb_bytes then reports the bytes delivered up to and including it.
- R10: wb_valid is a one-cycle pulse in the cycle after the final beat is accepted. A descriptor with byte count 0 gives no beats and reports in the cycle after it is taken. No descriptor is taken while a record is pending.
- R11: wb_irq is 1 with the record when it completes and control bit 0 is set, or has an error and control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_flags | input | 8 | Control byte (7 start, 6 end, 2 FIFO address, 1 irq on error, 0 irq on completion) |
| desc_bytes | input | 20 | Programmed byte count |
| desc_user | input | 64 | User control word |
| desc_addr | input | 32 | Card start address |
| rd_valid | input | 1 | Read data beat valid |
| rd_ready | output | 1 | Read data beat accepted |
| rd_data | input | 128 | Read data |
| rd_err | input | 3 | Beat error causes (2 ECRC, 1 poisoned, 0 unsuccessful) |
| rd_stop | input | 1 | This beat ends the descriptor early |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream beat taken |
| st_data | output | 128 | Stream data |
| st_keep | output | 16 | Byte enables |
| st_sop | output | 1 | Packet start |
| st_eop | output | 1 | Packet end |
| st_user | output | 64 | User word, start beat only |
| st_addr | output | 32 | Burst address |
| st_burst_first | output | 1 | First beat of a burst |
| wb_valid | output | 1 | Status record valid |
| wb_flags | output | 8 | Status flags |
| wb_errsrc | output | 4 | Error source field |
| wb_bytes | output | 20 | Bytes delivered |
| wb_irq | output | 1 | Interrupt request |

## Verification
The stream is exercised with a short packet whose last beat is partial, and with a 20-beat non-final descriptor that crosses a burst boundary and is stalled mid-burst. A 38-beat addressable-FIFO packet with a misaligned start address and two different error causes follows. It is followed by a clean single-beat packet, an early-ended descriptor, a zero-length descriptor and a bare continuation. The partial and exact-fit tails separate the keep-mask arithmetic from the end-flag gating. The burst crossing separates address stepping from FIFO-mode address pinning. The clean packet after the erroneous one shows whether the error sources are cleared when the next descriptor is taken. The early end and the zero length separate delivered bytes from programmed bytes, and so show how the short and complete flags are decided.

// File: rtl/s2c_pkg.sv
package s2c_pkg;
  // control byte bit positions
  localparam int F_SOP      = 7;
  localparam int F_EOP      = 6;
  localparam int F_AFIFO    = 2;
  localparam int F_IRQ_ERR  = 1;
  localparam int F_IRQ_DONE = 0;
  // status byte bit positions
  localparam int S_ERR   = 4;
  localparam int S_SHORT = 1;
  localparam int S_DONE  = 0;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_WB = 2'd2} emit_state_t;

  function automatic logic [7:0] make_status(input logic err, input logic shrt);
    logic [7:0] s;
    s = '0;
    s[S_ERR]   = err;
    s[S_SHORT] = shrt;
    s[S_DONE]  = ~err;
    return s;
  endfunction

  function automatic logic want_irq(input logic [7:0] cflags, input logic err);
    return (cflags[F_IRQ_DONE] & ~err) | (cflags[F_IRQ_ERR] & err);
  endfunction
endpackage

// File: rtl/s2c_burst_addr.sv
module s2c_burst_addr #(
  parameter int ADDR_W    = 32,
  parameter int BPB_LG    = 4,
  parameter int MAX_BURST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              fifo_mode,
  input  logic              fire,
  input  logic              desc_end,
  output logic [ADDR_W-1:0] burst_addr,
  output logic              burst_first,
  output logic              burst_close
);
  localparam int BEAT_W   = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
  localparam int ALIGN_LG = BPB_LG + $clog2(MAX_BURST);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'd1 << ALIGN_LG) - 64'd1);
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(MAX_BURST - 1);

  logic [BEAT_W-1:0] beat_idx;
  logic              fifo_q;
  logic [ADDR_W-1:0] step;

  assign burst_first = (beat_idx == '0);
  assign burst_close = fire & (desc_end | (beat_idx == LAST_IDX));
  assign step        = (ADDR_W'(beat_idx) + ADDR_W'(1)) << BPB_LG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx   <= '0;
      fifo_q     <= 1'b0;
      burst_addr <= '0;
    end else if (load) begin
      beat_idx   <= '0;
      fifo_q     <= fifo_mode;
      burst_addr <= fifo_mode ? (base_addr & ~ALIGN_MASK) : base_addr;
    end else if (burst_close) begin
      beat_idx <= '0;
      if (!fifo_q) burst_addr <= burst_addr + step;
    end else if (fire) begin
      beat_idx <= beat_idx + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/s2c_err_accum.sv
module s2c_err_accum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic [2:0] err_in,
  output logic [3:0] err_src,
  output logic       any_err
);
  logic [2:0] sticky;

  always_ff @(posedge clk) begin
    if (!rst_n)      sticky <= '0;
    else if (clear)  sticky <= '0;
    else if (sample) sticky <= sticky | err_in;
  end

  assign err_src = {1'b0, sticky};
  assign any_err = |sticky;
endmodule

// File: rtl/s2c_byte_track.sv
module s2c_byte_track #(
  parameter int CNT_W = 20,
  parameter int BPB   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_bytes,
  input  logic             fire,
  input  logic             stop,
  output logic [CNT_W-1:0] sent,
  output logic [CNT_W-1:0] beat_bytes,
  output logic             fin
);
  localparam logic [CNT_W-1:0] BPB_C = CNT_W'(BPB);

  logic [CNT_W-1:0] rem;

  assign beat_bytes = (rem < BPB_C) ? rem : BPB_C;
  assign fin        = (rem <= BPB_C) | stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      sent <= '0;
    end else if (load) begin
      rem  <= load_bytes;
      sent <= '0;
    end else if (fire) begin
      rem  <= rem - beat_bytes;
      sent <= sent + beat_bytes;
    end
  end
endmodule

// File: rtl/s2c_desc_emitter.sv
module s2c_desc_emitter #(
  parameter int DATA_W    = 128,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 20,
  parameter int USER_W    = 64,
  parameter int MAX_BURST = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  desc_valid,
  output logic                  desc_ready,
  input  logic [7:0]            desc_flags,
  input  logic [CNT_W-1:0]      desc_bytes,
  input  logic [USER_W-1:0]     desc_user,
  input  logic [ADDR_W-1:0]     desc_addr,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic [2:0]            rd_err,
  input  logic                  rd_stop,
  output logic                  st_valid,
  input  logic                  st_ready,
  output logic [DATA_W-1:0]     st_data,
  output logic [DATA_W/8-1:0]   st_keep,
  output logic                  st_sop,
  output logic                  st_eop,
  output logic [USER_W-1:0]     st_user,
  output logic [ADDR_W-1:0]     st_addr,
  output logic                  st_burst_first,
  output logic                  wb_valid,
  output logic [7:0]            wb_flags,
  output logic [3:0]            wb_errsrc,
  output logic [CNT_W-1:0]      wb_bytes,
  output logic                  wb_irq
);
  import s2c_pkg::*;

  localparam int BPB    = DATA_W / 8;
  localparam int BPB_LG = $clog2(BPB);

  emit_state_t       state;
  logic [7:0]        cflags;
  logic [USER_W-1:0] user_q;
  logic [CNT_W-1:0]  prog_bytes;
  logic              first_beat;

  logic             in_run, load, fire, fin, end_beat, any_err, burst_close;
  logic [CNT_W-1:0] sent, beat_bytes;
  logic [3:0]       err_src;

  function automatic logic [BPB-1:0] keep_for(input logic [CNT_W-1:0] n);
    logic [BPB-1:0] k;
    for (int i = 0; i < BPB; i++) k[i] = (CNT_W'(i) < n);
    return k;
  endfunction

  assign in_run     = (state == ST_RUN);
  assign desc_ready = (state == ST_IDLE);
  assign load       = desc_valid & desc_ready;
  assign st_valid   = in_run & rd_valid;
  assign rd_ready   = in_run & st_ready;
  assign fire       = st_valid & st_ready;
  assign end_beat   = in_run & fin;

  assign st_data = rd_data;
  assign st_sop  = in_run & first_beat & cflags[F_SOP];
  assign st_user = st_sop ? user_q : '0;
  assign st_eop  = end_beat & cflags[F_EOP];
  assign st_keep = st_eop ? keep_for(beat_bytes) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cflags     <= '0;
      user_q     <= '0;
      prog_bytes <= '0;
      first_beat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          cflags     <= desc_flags;
          user_q     <= desc_user;
          prog_bytes <= desc_bytes;
          first_beat <= 1'b1;
          state      <= (desc_bytes == '0) ? ST_WB : ST_RUN;
        end
        ST_RUN: if (fire) begin
          first_beat <= 1'b0;
          if (fin) state <= ST_WB;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  s2c_byte_track #(.CNT_W(CNT_W), .BPB(BPB)) u_bytes (
    .clk(clk), .rst_n(rst_n), .load(load), .load_bytes(desc_bytes),
    .fire(fire), .stop(rd_stop), .sent(sent), .beat_bytes(beat_bytes), .fin(fin)
  );

  s2c_burst_addr #(.ADDR_W(ADDR_W), .BPB_LG(BPB_LG), .MAX_BURST(MAX_BURST)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .base_addr(desc_addr),
    .fifo_mode(desc_flags[F_AFIFO]), .fire(fire), .desc_end(fin),
    .burst_addr(st_addr), .burst_first(st_burst_first), .burst_close(burst_close)
  );

  s2c_err_accum u_err (
    .clk(clk), .rst_n(rst_n), .clear(load), .sample(fire), .err_in(rd_err),
    .err_src(err_src), .any_err(any_err)
  );

  assign wb_valid  = (state == ST_WB);
  assign wb_flags  = wb_valid ? make_status(any_err, sent < prog_bytes) : '0;
  assign wb_errsrc = wb_valid ? err_src : '0;
  assign wb_bytes  = wb_valid ? sent : '0;
  assign wb_irq    = wb_valid & want_irq(cflags, any_err);
endmodule

// File: rtl/s2c_emitter_chk.sv
module s2c_emitter_chk #(
  parameter int KEEP_W = 16,
  parameter int USER_W = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_ready,
  input logic              st_valid,
  input logic              st_ready,
  input logic              rd_ready,
  input logic              st_sop,
  input logic              st_eop,
  input logic [KEEP_W-1:0] st_keep,
  input logic [USER_W-1:0] st_user,
  input logic [ADDR_W-1:0] st_addr,
  input logic              st_burst_first,
  input logic              wb_valid,
  input logic [7:0]        wb_flags,
  input logic [3:0]        wb_errsrc
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> (!st_valid && !wb_valid));
  // R2
  accept_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |-> rd_ready);
  // R3
  user_only_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_sop |-> (st_user == '0));
  // R4
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_eop) |-> (st_keep == '1));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_burst_first) |-> $stable(st_addr));
  // R10
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((wb_flags[4] == (wb_errsrc != 4'd0)) && (wb_flags[0] != wb_flags[4])));
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!wb_errsrc[3] && wb_flags[7:5] == 3'd0 && wb_flags[3:2] == 2'd0));
endmodule

bind s2c_desc_emitter s2c_emitter_chk #(.KEEP_W(BPB), .USER_W(USER_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .st_valid(st_valid),
  .st_ready(st_ready), .rd_ready(rd_ready), .st_sop(st_sop), .st_eop(st_eop),
  .st_keep(st_keep), .st_user(st_user), .st_addr(st_addr),
  .st_burst_first(st_burst_first), .wb_valid(wb_valid), .wb_flags(wb_flags),
  .wb_errsrc(wb_errsrc)
);

// File: tb/tb_s2c_desc_emitter.sv
module tb_s2c_desc_emitter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         desc_valid = 1'b0;
  logic         desc_ready;
  logic [7:0]   desc_flags = '0;
  logic [19:0]  desc_bytes = '0;
  logic [63:0]  desc_user = '0;
  logic [31:0]  desc_addr = '0;
  logic         rd_valid = 1'b0;
  logic         rd_ready;
  logic [127:0] rd_data = '0;
  logic [2:0]   rd_err = '0;
  logic         rd_stop = 1'b0;
  logic         st_valid;
  logic         st_ready = 1'b1;
  logic [127:0] st_data;
  logic [15:0]  st_keep;
  logic         st_sop, st_eop;
  logic [63:0]  st_user;
  logic [31:0]  st_addr;
  logic         st_burst_first;
  logic         wb_valid;
  logic [7:0]   wb_flags;
  logic [3:0]   wb_errsrc;
  logic [19:0]  wb_bytes;
  logic         wb_irq;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  s2c_desc_emitter dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_flags(desc_flags), .desc_bytes(desc_bytes), .desc_user(desc_user),
    .desc_addr(desc_addr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_err(rd_err), .rd_stop(rd_stop), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .st_keep(st_keep), .st_sop(st_sop),
    .st_eop(st_eop), .st_user(st_user), .st_addr(st_addr),
    .st_burst_first(st_burst_first), .wb_valid(wb_valid), .wb_flags(wb_flags),
    .wb_errsrc(wb_errsrc), .wb_bytes(wb_bytes), .wb_irq(wb_irq)
  );

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one descriptor end to end; e1/e2 inject error causes, stop_at ends early, stall_at holds st_ready low once
  task automatic run_desc(input string name, input logic [7:0] fl, input int bytes,
                          input logic [63:0] usr, input logic [31:0] addr,
                          input int e1, input logic [2:0] v1, input int e2, input logic [2:0] v2,
                          input int stop_at, input int stall_at);
    int nb, sent_exp, rem, bb;
    logic [2:0] acc;
    logic [31:0] a_exp;
    logic [15:0] k_exp;
    bit last, errd, shortd;
    nb = (bytes + 15) / 16;
    if (stop_at >= 0 && stop_at + 1 < nb) nb = stop_at + 1;
    acc = '0;
    sent_exp = 0;
    @(negedge clk);
    chk({name, " R1 ready in idle"}, desc_ready, 1'b1);
    desc_valid = 1'b1; desc_flags = fl; desc_bytes = 20'(bytes);
    desc_user = usr; desc_addr = addr;
    @(negedge clk);
    desc_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rem  = bytes - 16 * i;
      bb   = (rem < 16) ? rem : 16;
      last = (i == nb - 1);
      rd_valid = 1'b1;
      rd_data  = {4{32'(i) ^ 32'hA5C3_0000 ^ addr}};
      rd_err   = (i == e1 ? v1 : 3'd0) | (i == e2 ? v2 : 3'd0);
      rd_stop  = (i == stop_at);
      acc      = acc | rd_err;
      sent_exp = sent_exp + bb;
      if (i == stall_at) begin
        st_ready = 1'b0;
        #1;
        chk({name, " R2 stall blocks rd_ready"}, rd_ready, 1'b0);
        @(negedge clk);
        st_ready = 1'b1;
      end
      #1;
      if (fl[2]) a_exp = {addr[31:8], 8'h00};
      else       a_exp = addr + 32'(256 * (i / 16));
      k_exp = '1;
      if (last && fl[6] && bb < 16) k_exp = 16'((32'd1 << bb) - 1);
      chk({name, " R2 st_valid"}, st_valid, 1'b1);
      chk({name, " R2 data"}, st_data, rd_data);
      chk({name, " R3 sop"}, st_sop, (i == 0) && fl[7]);
      chk({name, " R3 user"}, st_user, ((i == 0) && fl[7]) ? usr : 64'd0);
      chk({name, " R4 eop"}, st_eop, last && fl[6]);
      chk({name, " R4 keep"}, st_keep, k_exp);
      chk({name, fl[2] ? " R6 fifo addr" : " R5 addr"}, st_addr, a_exp);
      chk({name, " R5 burst_first"}, st_burst_first, (i % 16) == 0);
      @(negedge clk);
      rd_valid = 1'b0; rd_err = '0; rd_stop = 1'b0;
    end
    errd   = (acc != 3'd0);
    shortd = (sent_exp < bytes);
    chk({name, " R10 wb pulse"}, wb_valid, 1'b1);
    chk({name, " R7 errsrc"}, wb_errsrc, {1'b0, acc});
    chk({name, " R8 flags"}, wb_flags, {3'b000, errd, 2'b00, shortd, !errd});
    chk({name, " R9 bytes"}, wb_bytes, 20'(sent_exp));
    chk({name, " R11 irq"}, wb_irq, (!errd && fl[0]) || (errd && fl[1]));
    chk({name, " R10 not ready during wb"}, desc_ready, 1'b0);
    @(negedge clk);
    chk({name, " R10 wb single"}, wb_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset desc_ready", desc_ready, 1'b1);
    chk("R1 reset st_valid", st_valid, 1'b0);
    chk("R1 reset wb_valid", wb_valid, 1'b0);
    // short packet, partial tail of 8 bytes
    run_desc("single", 8'hC1, 40, 64'hDEAD_BEEF_0123_4567, 32'h0000_1000, -1, 0, -1, 0, -1, -1);
    // 20 beats crossing a burst, stalled in burst 1
    run_desc("burst", 8'h80, 320, 64'h1111_2222_3333_4444, 32'h2000_0040, -1, 0, -1, 0, -1, 5);
    // FIFO mode, misaligned address, poisoned + ECRC errors
    run_desc("fifo", 8'h46, 600, 64'h0, 32'h3000_0123, 3, 3'b010, 20, 3'b100, -1, -1);
    // clean exact-fit beat right after errors: sources cleared (R7)
    run_desc("clean", 8'hC2, 16, 64'hCAFE_F00D_0000_0001, 32'h0000_4000, -1, 0, -1, 0, -1, -1);
    // early end on beat 2 with an unsuccessful completion
    run_desc("trunc", 8'h43, 100, 64'h0, 32'h0000_5000, 0, 3'b001, -1, 0, 2, -1);
    // zero length
    run_desc("zero", 8'hC1, 0, 64'h77, 32'h0000_6000, -1, 0, -1, 0, -1, -1);
    // continuation, no framing bits, partial tail keeps full mask
    run_desc("cont", 8'h00, 24, 64'h99, 32'h0000_7000, -1, 0, -1, 0, -1, -1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule